// File: doc/BRIEF.md
# Prioritised Two-Bank Interrupt Controller

The block collects up to 32 interrupt request lines. It presents them to a processor through two independent output banks: a normal bank driving `irq_o` and a fast bank driving `fiq_o`. Every line passes through a shared conditioning stage. That stage can invert the line's polarity and can either follow the line as a level or capture it in a latch that holds until software acknowledges it. Each line carries a priority value that both banks share, where a smaller number means more urgent.

Each bank keeps its own enable mask and priority threshold. A line is eligible in a bank when it is pending, enabled in that bank, and its priority number does not exceed the bank's threshold. Software polls the bank's status word, reads the bank's current-source word to learn the winning line, and acknowledges by reading the bank's acknowledge word. That read returns the winner and releases its latch. Access goes through a plain register port: single-cycle write strobes, and read data registered one cycle after the read strobe.

Top module: `prio_intc`

## Requirements
- R1: After reset the enable masks of both banks are 0, both thresholds are 0xF, the polarity word (0x200) is all ones, the latch-select word (0x204) is 0, all priorities are 0, and `irq_o`/`fiq_o` are low.
- R2: Writing a word to a bank's enable-set address (offset 0x08) sets the enable bits where it has ones. Writing to the enable-clear address (offset 0x0C) clears them. Zero bits leave enables unchanged, and either offset reads back the enable mask.
- R3: Bit i of the polarity word at 0x200 passes line i unchanged when 1 and inverts it when 0. The raw word (bank offset 0x04) shows every pending line after polarity and before enable masking.
- R4: Bit i of the latch-select word at 0x204 set to 1 makes line i pending from its first active cycle until acknowledged. Set to 0, the line is pending exactly while active.
- R5: A bank's status word (offset 0x00) is the set of its eligible lines. The bank's output goes high one clock after the status becomes nonzero and low one clock after it becomes zero.
- R6: A bank's current word (offset 0x20) is the eligible line with the smallest priority number, with ties going to the lowest line number. It reads NUM_SRC when no line is eligible.
- R7: A bank's threshold (offset 0x2C, low 4 bits) admits only lines whose priority number is less than or equal to it. 0xF admits all lines.
- R8: Reading a bank's acknowledge word (offset 0x28) returns the same value as the current word and clears the latch of that winning line. Level lines still active remain pending.
- R9: The normal bank occupies offsets from 0x000 and the fast bank from 0x100. Enables, thresholds, status and outputs of one bank do not affect the other.
- R10: The priority of line i is a 4-bit value at 0x300 + 4*i, read and written in the low bits. Read data appears on `rdata` in the cycle after the `rd_en` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal-bank request, registered |
| fiq_o | output | 1 | Fast-bank request, registered |

## Verification
The bench builds the block with its defaults: NUM_SRC = 32, PRIO_W = 4 and ADDR_W = 12. With these values the top line 31 and its priority word at 0x37C are reachable. The full threshold range is covered, including a line at priority 15 admitted only under threshold 0xF. The "nothing eligible" code, 32, sits just beyond the last line number. Scenarios exercise priority ties, thresholds that exclude every pending line, latched lines acknowledged in the fast bank while the normal bank stays idle, and level lines that survive an acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DATA_W = 32;

  // per-bank register offsets (low byte of the address)
  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_RAW    = 8'h04;
  localparam logic [7:0] OFF_EN_SET = 8'h08;
  localparam logic [7:0] OFF_EN_CLR = 8'h0C;
  localparam logic [7:0] OFF_CUR    = 8'h20;
  localparam logic [7:0] OFF_ACK    = 8'h28;
  localparam logic [7:0] OFF_THR    = 8'h2C;

  // shared registers
  localparam logic [11:0] ADR_POL    = 12'h200;
  localparam logic [11:0] ADR_LATSEL = 12'h204;
  localparam logic [3:0]  PAGE_PRIO  = 4'h3;

  typedef enum logic {BANK_NORM = 1'b0, BANK_FAST = 1'b1} bank_e;

  typedef struct packed {
    logic set_en;
    logic clr_en;
    logic wr_thr;
    logic ack;
  } bank_cmd_t;
endpackage

// File: rtl/pic_srcstage.sv
module pic_srcstage #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               pol_wr,
  input  logic               latsel_wr,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] clr_mask,
  output logic [NUM_SRC-1:0] pol_q,
  output logic [NUM_SRC-1:0] latsel_q,
  output logic [NUM_SRC-1:0] latch_q,
  output logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] active;

  // polarity bit 1 passes the line through, 0 inverts it
  assign active = src_i ^ ~pol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q    <= '1;
      latsel_q <= '0;
      latch_q  <= '0;
    end else begin
      if (pol_wr)    pol_q    <= wdata;
      if (latsel_wr) latsel_q <= wdata;
      latch_q <= ((latch_q & ~clr_mask) | active) & latsel_q;
    end
  end

  // a latched line counts as pending from its first active cycle
  assign pend = (active & ~latsel_q) | ((latch_q | active) & latsel_q);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        elig,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      found,
  output logic [SRC_W-1:0]          idx
);
  logic [PRIO_W-1:0] best;

  // scan downward so that on equal priority the lower number wins last
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (elig[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] <= best)) begin
        found = 1'b1;
        best  = prio_flat[i*PRIO_W +: PRIO_W];
        idx   = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_bank.sv
module pic_bank
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  bank_cmd_t                 cmd,
  input  logic [NUM_SRC-1:0]        wmask,
  input  logic [PRIO_W-1:0]         wthr,
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic [NUM_SRC-1:0]        en_q,
  output logic [PRIO_W-1:0]         thr_q,
  output logic [NUM_SRC-1:0]        elig,
  output logic                      found,
  output logic [SRC_W-1:0]          cur,
  output logic                      req_q
);
  logic [NUM_SRC-1:0] under_thr;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_thr
    assign under_thr[g] = prio_flat[g*PRIO_W +: PRIO_W] <= thr_q;
  end

  assign elig = pend & en_q & under_thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      thr_q <= '1;
      req_q <= 1'b0;
    end else begin
      if (cmd.set_en)      en_q <= en_q | wmask;
      else if (cmd.clr_en) en_q <= en_q & ~wmask;
      if (cmd.wr_thr) thr_q <= wthr;
      req_q <= |elig;
    end
  end

  pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
    .elig      (elig),
    .prio_flat (prio_flat),
    .found     (found),
    .idx       (cur)
  );
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int HI_W   = ADDR_W - 8;
  localparam int NBANK  = 2;

  // address decode
  logic             in_bank, bank_sel, is_pol, is_latsel, is_prio;
  logic [7:0]       off;
  logic [SRC_W-1:0] prio_idx;

  assign off       = addr[7:0];
  assign bank_sel  = addr[8];
  assign in_bank   = (addr[ADDR_W-1:9] == '0);
  assign is_pol    = (addr == ADDR_W'(ADR_POL));
  assign is_latsel = (addr == ADDR_W'(ADR_LATSEL));
  assign is_prio   = (addr[ADDR_W-1:8] == HI_W'(PAGE_PRIO)) &&
                     (addr[1:0] == 2'b00) && (int'(addr[7:2]) < NUM_SRC);
  assign prio_idx  = addr[SRC_W+1:2];

  // priority storage, one word per line
  logic [PRIO_W-1:0]         prio_q [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SRC; i++) prio_q[i] <= '0;
    end else if (wr_en && is_prio) begin
      prio_q[prio_idx] <= wdata[PRIO_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pflat
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  // line conditioning
  logic [NUM_SRC-1:0] src_pol, src_latsel, src_latch, src_pend, clr_mask;

  pic_srcstage #(.NUM_SRC(NUM_SRC)) u_src (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .pol_wr    (wr_en && is_pol),
    .latsel_wr (wr_en && is_latsel),
    .wdata     (wdata[NUM_SRC-1:0]),
    .clr_mask  (clr_mask),
    .pol_q     (src_pol),
    .latsel_q  (src_latsel),
    .latch_q   (src_latch),
    .pend      (src_pend)
  );

  // two banks
  bank_cmd_t [NBANK-1:0]              bank_cmd;
  logic [NBANK-1:0][NUM_SRC-1:0]      bank_en, bank_elig, ack_mask;
  logic [NBANK-1:0][PRIO_W-1:0]       bank_thr;
  logic [NBANK-1:0][SRC_W-1:0]        bank_cur;
  logic [NBANK-1:0]                   bank_found, bank_req;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = in_bank && (bank_sel == b[0]);
    assign bank_cmd[b].set_en = wr_en && hit && (off == OFF_EN_SET);
    assign bank_cmd[b].clr_en = wr_en && hit && (off == OFF_EN_CLR);
    assign bank_cmd[b].wr_thr = wr_en && hit && (off == OFF_THR);
    assign bank_cmd[b].ack    = rd_en && hit && (off == OFF_ACK);

    assign ack_mask[b] = (bank_cmd[b].ack && bank_found[b]) ?
                         (NUM_SRC'(1) << bank_cur[b]) : '0;

    pic_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .cmd       (bank_cmd[b]),
      .wmask     (wdata[NUM_SRC-1:0]),
      .wthr      (wdata[PRIO_W-1:0]),
      .pend      (src_pend),
      .prio_flat (prio_flat),
      .en_q      (bank_en[b]),
      .thr_q     (bank_thr[b]),
      .elig      (bank_elig[b]),
      .found     (bank_found[b]),
      .cur       (bank_cur[b]),
      .req_q     (bank_req[b])
    );
  end

  assign clr_mask = ack_mask[0] | ack_mask[1];
  assign irq_o    = bank_req[BANK_NORM];
  assign fiq_o    = bank_req[BANK_FAST];

  // read path
  logic [31:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (in_bank) begin
      unique case (off)
        OFF_STATUS:         rd_val = DATA_W'(bank_elig[bank_sel]);
        OFF_RAW:            rd_val = DATA_W'(src_pend);
        OFF_EN_SET,
        OFF_EN_CLR:         rd_val = DATA_W'(bank_en[bank_sel]);
        OFF_CUR, OFF_ACK:   rd_val = bank_found[bank_sel] ?
                                     DATA_W'(bank_cur[bank_sel]) : DATA_W'(NUM_SRC);
        OFF_THR:            rd_val = DATA_W'(bank_thr[bank_sel]);
        default:            rd_val = '0;
      endcase
    end else if (is_pol) begin
      rd_val = DATA_W'(src_pol);
    end else if (is_latsel) begin
      rd_val = DATA_W'(src_latsel);
    end else if (is_prio) begin
      rd_val = DATA_W'(prio_q[prio_idx]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 12,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             addr,
  input logic [NUM_SRC-1:0]            wmask,
  input logic                          irq_o,
  input logic                          fiq_o,
  input logic [1:0][NUM_SRC-1:0]       en,
  input logic [1:0][NUM_SRC-1:0]       elig,
  input logic [1:0][SRC_W-1:0]         cur,
  input logic [1:0][PRIO_W-1:0]        thr,
  input logic [NUM_SRC*PRIO_W-1:0]     prio_flat,
  input logic [NUM_SRC-1:0]            latch,
  input logic [NUM_SRC-1:0]            latsel,
  input logic [NUM_SRC-1:0]            clr
);
  function automatic logic beaten(input logic [NUM_SRC-1:0] e,
                                  input logic [NUM_SRC*PRIO_W-1:0] p,
                                  input logic [SRC_W-1:0] c);
    logic r;
    logic [PRIO_W-1:0] pc;
    r  = 1'b0;
    pc = p[int'(c)*PRIO_W +: PRIO_W];
    for (int j = 0; j < NUM_SRC; j++) begin
      if (e[j] && ((p[j*PRIO_W +: PRIO_W] < pc) ||
                   ((p[j*PRIO_W +: PRIO_W] == pc) && (j < int'(c))))) r = 1'b1;
    end
    return r;
  endfunction

  // R1: outputs quiet right after a reset cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_o && !fiq_o));

  // R2: enable-set write leaves every written one enabled
  assert_enable_set_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(addr) == ADDR_W'(12'h008)) |->
      ((en[0] & $past(wmask)) == $past(wmask)));

  // R4: a latch only drops through acknowledge or deselection
  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (($past(latch) & $past(latsel) & ~$past(clr) & ~latch) == '0));

  // R6: the reported winner is eligible and unbeaten, per bank
  assert_winner_norm_R6: assert property (@(posedge clk) disable iff (rst)
    (|elig[0]) |-> (elig[0][cur[0]] && !beaten(elig[0], prio_flat, cur[0])));
  assert_winner_fast_R6: assert property (@(posedge clk) disable iff (rst)
    (|elig[1]) |-> (elig[1][cur[1]] && !beaten(elig[1], prio_flat, cur[1])));

  // R7: the winner respects the bank threshold
  assert_threshold_R7: assert property (@(posedge clk) disable iff (rst)
    (|elig[0]) |-> (prio_flat[int'(cur[0])*PRIO_W +: PRIO_W] <= thr[0]));
endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .addr      (addr),
  .wmask     (wdata[NUM_SRC-1:0]),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .en        (bank_en),
  .elig      (bank_elig),
  .cur       (bank_cur),
  .thr       (bank_thr),
  .prio_flat (prio_flat),
  .latch     (src_latch),
  .latsel    (src_latsel),
  .clr       (clr_mask)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst(rst), .src_i(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_v = 1'b0;

  always @(posedge clk) mon_v <= rd_en;

  always @(negedge clk) begin
    if (mon_v) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: actual %h", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", t, act, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    settle(3);
    rst = 1'b0;
    settle(1);

    // R1 reset state
    pin(irq_o, 1'b0, "R1 irq_o");
    pin(fiq_o, 1'b0, "R1 fiq_o");
    rd(12'h008, 32'h0, "R1 norm enable");
    rd(12'h02C, 32'hF, "R1 norm threshold");
    rd(12'h12C, 32'hF, "R1 fast threshold");
    rd(12'h200, 32'hFFFF_FFFF, "R1 polarity");
    rd(12'h204, 32'h0, "R1 latch select");
    rd(12'h300, 32'h0, "R1 priority 0");
    rd(12'h020, 32'd32, "R6 none eligible");

    // R2 set/clear enables
    wr(12'h008, 32'h0000_00F0);
    wr(12'h008, 32'h0000_0003);
    rd(12'h008, 32'h0000_00F3, "R2 set accumulates");
    wr(12'h00C, 32'h0000_0011);
    rd(12'h00C, 32'h0000_00E2, "R2 clear ones only");
    rd(12'h108, 32'h0, "R9 fast enable untouched");
    wr(12'h00C, 32'hFFFF_FFFF);

    // R5 level line in normal bank
    wr(12'h008, 32'h0000_0020);
    src[5] = 1'b1;
    settle(2);
    pin(irq_o, 1'b1, "R5 irq_o asserted");
    pin(fiq_o, 1'b0, "R9 fiq_o idle");
    rd(12'h000, 32'h0000_0020, "R5 status");
    rd(12'h020, 32'd5, "R6 current single");
    rd(12'h120, 32'd32, "R9 fast current none");
    src[9] = 1'b1;
    rd(12'h004, 32'h0000_0220, "R3 raw before enable");
    rd(12'h000, 32'h0000_0020, "R3 status masked");
    src[5] = 1'b0; src[9] = 1'b0;
    settle(2);
    pin(irq_o, 1'b0, "R5 irq_o released");
    rd(12'h000, 32'h0, "R4 level line drops");

    // R3 polarity
    wr(12'h200, 32'hFFFF_FF7F);
    rd(12'h004, 32'h0000_0080, "R3 inverted line pending");
    wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h004, 32'h0, "R3 pass-through restored");

    // R6/R10 priority arbitration
    wr(12'h30C, 32'h5);
    wr(12'h328, 32'h2);
    rd(12'h328, 32'h2, "R10 priority word line 10");
    wr(12'h008, 32'h0000_0408);
    src[3] = 1'b1; src[10] = 1'b1;
    rd(12'h020, 32'd10, "R6 smaller priority wins");
    wr(12'h328, 32'h5);
    rd(12'h020, 32'd3, "R6 tie lowest number");
    wr(12'h328, 32'h2);

    // R7 threshold
    wr(12'h02C, 32'h1);
    settle(2);
    pin(irq_o, 1'b0, "R7 all above threshold");
    rd(12'h000, 32'h0, "R7 status empty");
    rd(12'h020, 32'd32, "R7 current none");
    wr(12'h02C, 32'h2);
    rd(12'h000, 32'h0000_0400, "R7 partial admit");
    rd(12'h020, 32'd10, "R7 winner at threshold");
    wr(12'h02C, 32'hF);
    wr(12'h37C, 32'hF);
    wr(12'h008, 32'h8000_0000);
    src[31] = 1'b1;
    rd(12'h000, 32'h8000_0408, "R7 0xF admits priority 15");
    rd(12'h37C, 32'hF, "R10 last priority word");
    rd(12'h020, 32'd10, "R6 winner kept");
    src[3] = 1'b0; src[10] = 1'b0; src[31] = 1'b0;
    wr(12'h00C, 32'hFFFF_FFFF);

    // R4/R8 latched line in fast bank
    wr(12'h204, 32'h0000_1000);
    wr(12'h108, 32'h0000_1000);
    @(negedge clk); src[12] = 1'b1;
    @(negedge clk); src[12] = 1'b0;
    settle(2);
    pin(fiq_o, 1'b1, "R4 latched fiq_o");
    pin(irq_o, 1'b0, "R9 irq_o idle");
    rd(12'h100, 32'h0000_1000, "R4 latched status");
    rd(12'h128, 32'd12, "R8 ack returns winner");
    rd(12'h100, 32'h0, "R8 latch cleared");
    settle(2);
    pin(fiq_o, 1'b0, "R8 fiq_o released");
    rd(12'h128, 32'd32, "R8 ack with none");

    // R8 level line survives acknowledge
    wr(12'h108, 32'h0000_0040);
    src[6] = 1'b1;
    rd(12'h128, 32'd6, "R8 level ack");
    rd(12'h100, 32'h0000_0040, "R8 level still pending");
    src[6] = 1'b0;
    rd(12'h100, 32'h0, "R4 level gone");

    settle(3);
    finish_run();
  end
endmodule